// File: doc/BRIEF.md
# BCH Sector Bit-Flip Applier

This block sits between a BCH error locator and the byte buffers that hold one 512-byte sector and its ECC bytes. A job starts with a one-cycle `start` pulse that captures the strength mode, the ECC bytes read back from the spare area (stored) and the ECC bytes the encoder produced while the sector streamed in (computed). Two screens run next. A computed code that is all zero means the sector is clean. A stored code that is all 0xFF means the page is erased. Either result ends the job at once with no corrections.

If neither screen ends the job, the block presents the computed code with its bytes reversed, ready for the locator. It then takes an error count and a stream of error locations. Each location is a bit index counted backwards from the end of the data-plus-ECC codeword. The block maps it to a data byte, an ECC byte, or an invalid flag. Each valid flip is a two-cycle read-modify-write on the selected buffer. A final status reports how many bits were corrected, or that an error occurred.

Two modes exist. The 8-bit strength mode has a 14-byte ECC slot of which 13 bytes carry code. The 16-bit strength mode has 26 code bytes. Byte i of any ECC vector occupies bits [8i+7:8i].

Top module: `ecc_flip_unit`

## Requirements
- R1: When every slot byte of the computed ECC is 0x00, the job ends with no buffer access. The slot is 14 bytes in 8-bit mode and 26 in 16-bit mode, and bytes outside the slot are ignored. `done` is high in the second cycle after the `start` cycle, with `res_kind`=1, `res_err`=0 and `res_fixed`=0.
- R2: When R1 does not apply and every slot byte of the stored ECC is 0xFF, the job ends with the same timing as R1 and no buffer access, with `res_kind`=2, `res_err`=0 and `res_fixed`=0.
- R3: When neither screen ends the job, `syn_valid` is high from the second cycle after `start` until the count is accepted. While `syn_valid` is high, `syn_out` holds the computed ECC reversed. In 16-bit mode, output byte i is computed byte 25−i. In 8-bit mode, output byte i is computed byte 12−i for i<13, byte 13 passes through unchanged, and bytes 14 to 25 are zero.
- R4: The codeword limit is 525 in 8-bit mode and 538 in 16-bit mode. A location L maps to byte position limit−1−floor(L/8) and bit L mod 8. A position below 512 flips that bit of data byte `position`.
- R5: A position of 512 or more (and below the limit) flips bit L mod 8 of ECC byte position−512.
- R6: A location with floor(L/8) at or above the limit is invalid. No flip is made for it or for any later location of the job, but the later locations are still accepted. The job then ends with `res_err`=1 and `res_fixed`=0.
- R7: A valid location accepted at a clock edge produces a read strobe on the selected buffer in the next cycle. The cycle after that carries a write to the same address of the returned byte XOR a one-hot bit mask. The next location is accepted in the cycle after the write. An invalid or suppressed location uses no buffer cycle.
- R8: The count is a 5-bit value taken through `cnt_valid`/`cnt_ready`, and values above 16 are treated as 16. A count of zero ends the job in the cycle after the count is accepted.
- R9: A job without error ends with `res_kind`=0, `res_err`=0 and `res_fixed` equal to the number of flips applied. `done` is a one-cycle pulse, and `busy` is low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a job; taken only while idle |
| mode16 | input | 1 | 1 selects 16-bit strength, 0 selects 8-bit |
| stored_ecc | input | 208 | ECC bytes read from the spare area |
| calc_ecc | input | 208 | ECC bytes computed over the sector |
| busy | output | 1 | A job is in progress |
| syn_valid | output | 1 | Reversed code is presented to the locator |
| syn_out | output | 208 | Byte-reversed computed code |
| cnt_valid | input | 1 | Error count offered |
| cnt_ready | output | 1 | Count can be accepted |
| cnt_value | input | 5 | Number of locations to follow |
| loc_valid | input | 1 | Location offered |
| loc_ready | output | 1 | Location can be accepted |
| loc_value | input | 13 | Bit location counted from the codeword end |
| dbuf_rd | output | 1 | Data buffer read strobe |
| dbuf_wr | output | 1 | Data buffer write strobe |
| dbuf_addr | output | 9 | Data buffer byte address |
| dbuf_rdata | input | 8 | Data buffer read byte, one cycle after the strobe |
| dbuf_wdata | output | 8 | Data buffer write byte |
| ebuf_rd | output | 1 | ECC buffer read strobe |
| ebuf_wr | output | 1 | ECC buffer write strobe |
| ebuf_addr | output | 5 | ECC buffer byte address |
| ebuf_rdata | input | 8 | ECC buffer read byte, one cycle after the strobe |
| ebuf_wdata | output | 8 | ECC buffer write byte |
| done | output | 1 | Job finished; status valid this cycle |
| res_err | output | 1 | An invalid location was seen |
| res_kind | output | 2 | 0 located, 1 clean, 2 erased |
| res_fixed | output | 5 | Bits corrected, zero on error |

## Verification
For a screened job, the bench samples `done` and the status exactly two cycles after the `start` cycle. For other jobs, it checks `syn_valid` and the reversed code at that same point. When a location is accepted, the bench expects the read strobe one cycle later and the write one cycle after that. A suppressed location must instead be followed in the next cycle by the next handshake, or by `done`, with no strobe in between. Every write is compared in its own cycle against a queue of expected address and mask pairs that the bench derives from the location arithmetic. The data written must equal the bench's buffer copy XOR the mask, so repeated flips of one byte are checked against the buffer state left by the earlier flip.

// File: rtl/ecc_flip_pkg.sv
package ecc_flip_pkg;
  localparam int SEC_BYTES = 512;
  localparam int B8_USED   = 13;
  localparam int B8_SLOT   = 14;
  localparam int B16_USED  = 26;
  localparam int ECC_SLOT  = B16_USED;
  localparam int ECC_W     = ECC_SLOT * 8;
  localparam int POS_W     = $clog2(SEC_BYTES + ECC_SLOT);
  localparam int LOC_W     = POS_W + 3;
  localparam int DADDR_W   = $clog2(SEC_BYTES);
  localparam int EADDR_W   = $clog2(ECC_SLOT);

  typedef enum logic [2:0] {
    S_IDLE, S_SCREEN, S_COUNT, S_LOC, S_READ, S_WRITE, S_DONE
  } fsm_t;

  typedef enum logic [1:0] {
    K_LOCATED = 2'd0, K_CLEAN = 2'd1, K_ERASED = 2'd2
  } kind_t;

  typedef struct packed {
    logic               bad;
    logic               to_ecc;
    logic [DADDR_W-1:0] idx;
    logic [2:0]         bsel;
  } steer_t;

  // end of the data-plus-code word, in bytes
  function automatic logic [POS_W-1:0] cw_limit(input logic m16);
    return m16 ? POS_W'(SEC_BYTES + B16_USED) : POS_W'(SEC_BYTES + B8_USED);
  endfunction

  // map a backwards-counted bit location onto a buffer and byte
  function automatic steer_t steer_loc(input logic [LOC_W-1:0] loc, input logic m16);
    steer_t           s;
    logic [POS_W-1:0] lim;
    logic [POS_W-1:0] off;
    logic [POS_W-1:0] pos;
    lim      = cw_limit(m16);
    off      = loc[LOC_W-1:3];
    pos      = lim - POS_W'(1) - off;
    s.bad    = (off >= lim);
    s.to_ecc = !s.bad && (pos >= POS_W'(SEC_BYTES));
    s.idx    = s.to_ecc ? DADDR_W'(pos - POS_W'(SEC_BYTES)) : pos[DADDR_W-1:0];
    s.bsel   = loc[2:0];
    return s;
  endfunction

  function automatic logic [7:0] bit_mask(input logic [2:0] b);
    return 8'(1) << b;
  endfunction
endpackage

// File: rtl/ecc_screen.sv
module ecc_screen
  import ecc_flip_pkg::*;
(
  input  logic             mode16,
  input  logic [ECC_W-1:0] stored,
  input  logic [ECC_W-1:0] calc,
  output logic             is_clean,
  output logic             is_erased
);
  logic [ECC_SLOT-1:0] zero_ok;
  logic [ECC_SLOT-1:0] ff_ok;

  for (genvar i = 0; i < ECC_SLOT; i++) begin : g_byte
    logic active;
    if (i < B8_SLOT) begin : g_always
      assign active = 1'b1;
    end else begin : g_wide
      assign active = mode16;
    end
    assign zero_ok[i] = !active || (calc[8*i +: 8] == 8'h00);
    assign ff_ok[i]   = !active || (stored[8*i +: 8] == 8'hFF);
  end

  assign is_clean  = &zero_ok;
  assign is_erased = &ff_ok;
endmodule

// File: rtl/ecc_syn_reverse.sv
module ecc_syn_reverse
  import ecc_flip_pkg::*;
(
  input  logic             mode16,
  input  logic [ECC_W-1:0] calc,
  output logic [ECC_W-1:0] syn
);
  logic [ECC_W-1:0] r8;
  logic [ECC_W-1:0] r16;

  for (genvar i = 0; i < ECC_SLOT; i++) begin : g_byte
    assign r16[8*i +: 8] = calc[8*(B16_USED-1-i) +: 8];
    if (i < B8_USED) begin : g_rev
      assign r8[8*i +: 8] = calc[8*(B8_USED-1-i) +: 8];
    end else if (i < B8_SLOT) begin : g_keep
      assign r8[8*i +: 8] = calc[8*i +: 8];
    end else begin : g_zero
      assign r8[8*i +: 8] = 8'h00;
    end
  end

  assign syn = mode16 ? r16 : r8;
endmodule

// File: rtl/ecc_loc_steer.sv
module ecc_loc_steer
  import ecc_flip_pkg::*;
(
  input  logic             mode16,
  input  logic [LOC_W-1:0] loc,
  output steer_t           info
);
  assign info = steer_loc(loc, mode16);
endmodule

// File: rtl/ecc_flip_unit.sv
module ecc_flip_unit
  import ecc_flip_pkg::*;
#(
  parameter int MAX_LOC = 16,
  localparam int CNT_W = $clog2(MAX_LOC + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               mode16,
  input  logic [ECC_W-1:0]   stored_ecc,
  input  logic [ECC_W-1:0]   calc_ecc,
  output logic               busy,
  output logic               syn_valid,
  output logic [ECC_W-1:0]   syn_out,
  input  logic               cnt_valid,
  output logic               cnt_ready,
  input  logic [CNT_W-1:0]   cnt_value,
  input  logic               loc_valid,
  output logic               loc_ready,
  input  logic [LOC_W-1:0]   loc_value,
  output logic               dbuf_rd,
  output logic               dbuf_wr,
  output logic [DADDR_W-1:0] dbuf_addr,
  input  logic [7:0]         dbuf_rdata,
  output logic [7:0]         dbuf_wdata,
  output logic               ebuf_rd,
  output logic               ebuf_wr,
  output logic [EADDR_W-1:0] ebuf_addr,
  input  logic [7:0]         ebuf_rdata,
  output logic [7:0]         ebuf_wdata,
  output logic               done,
  output logic               res_err,
  output logic [1:0]         res_kind,
  output logic [CNT_W-1:0]   res_fixed
);
  fsm_t               state;
  logic               mode_q;
  logic [ECC_W-1:0]   stored_q;
  logic [ECC_W-1:0]   calc_q;
  logic [CNT_W-1:0]   left_q;
  logic [CNT_W-1:0]   fixed_q;
  logic               err_q;
  kind_t              kind_q;
  logic               tgt_ecc;
  logic [DADDR_W-1:0] tgt_idx;
  logic [2:0]         tgt_bit;

  logic               scr_clean;
  logic               scr_erased;
  steer_t             st_now;
  logic [CNT_W-1:0]   cnt_eff;
  logic [7:0]         flip;

  // named internal events, observed by the checker
  logic ev_clean;
  logic ev_erased;
  logic ev_accept;
  logic ev_bad;

  ecc_screen u_screen (
    .mode16   (mode_q),
    .stored   (stored_q),
    .calc     (calc_q),
    .is_clean (scr_clean),
    .is_erased(scr_erased)
  );

  ecc_syn_reverse u_rev (
    .mode16(mode_q),
    .calc  (calc_q),
    .syn   (syn_out)
  );

  ecc_loc_steer u_steer (
    .mode16(mode_q),
    .loc   (loc_value),
    .info  (st_now)
  );

  assign cnt_eff   = (cnt_value > CNT_W'(MAX_LOC)) ? CNT_W'(MAX_LOC) : cnt_value;
  assign flip      = bit_mask(tgt_bit);

  assign ev_clean  = (state == S_SCREEN) && scr_clean;
  assign ev_erased = (state == S_SCREEN) && !scr_clean && scr_erased;
  assign ev_accept = loc_valid && loc_ready;
  assign ev_bad    = ev_accept && (err_q || st_now.bad);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      mode_q   <= 1'b0;
      stored_q <= '0;
      calc_q   <= '0;
      left_q   <= '0;
      fixed_q  <= '0;
      err_q    <= 1'b0;
      kind_q   <= K_LOCATED;
      tgt_ecc  <= 1'b0;
      tgt_idx  <= '0;
      tgt_bit  <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          if (start) begin
            mode_q   <= mode16;
            stored_q <= stored_ecc;
            calc_q   <= calc_ecc;
            fixed_q  <= '0;
            err_q    <= 1'b0;
            kind_q   <= K_LOCATED;
            state    <= S_SCREEN;
          end
        end
        S_SCREEN: begin
          if (scr_clean) begin
            kind_q <= K_CLEAN;
            state  <= S_DONE;
          end else if (scr_erased) begin
            kind_q <= K_ERASED;
            state  <= S_DONE;
          end else begin
            state <= S_COUNT;
          end
        end
        S_COUNT: begin
          if (cnt_valid) begin
            left_q <= cnt_eff;
            state  <= (cnt_eff == '0) ? S_DONE : S_LOC;
          end
        end
        S_LOC: begin
          if (loc_valid) begin
            left_q <= left_q - CNT_W'(1);
            if (err_q || st_now.bad) begin
              if (st_now.bad) err_q <= 1'b1;
              state <= (left_q == CNT_W'(1)) ? S_DONE : S_LOC;
            end else begin
              tgt_ecc <= st_now.to_ecc;
              tgt_idx <= st_now.idx;
              tgt_bit <= st_now.bsel;
              state   <= S_READ;
            end
          end
        end
        S_READ:  state <= S_WRITE;
        S_WRITE: begin
          fixed_q <= fixed_q + CNT_W'(1);
          state   <= (left_q == '0) ? S_DONE : S_LOC;
        end
        S_DONE:  state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy       = (state != S_IDLE);
  assign syn_valid  = (state == S_COUNT);
  assign cnt_ready  = (state == S_COUNT);
  assign loc_ready  = (state == S_LOC);
  assign done       = (state == S_DONE);

  assign dbuf_rd    = (state == S_READ)  && !tgt_ecc;
  assign ebuf_rd    = (state == S_READ)  &&  tgt_ecc;
  assign dbuf_wr    = (state == S_WRITE) && !tgt_ecc;
  assign ebuf_wr    = (state == S_WRITE) &&  tgt_ecc;
  assign dbuf_addr  = tgt_idx;
  assign ebuf_addr  = tgt_idx[EADDR_W-1:0];
  assign dbuf_wdata = dbuf_rdata ^ flip;
  assign ebuf_wdata = ebuf_rdata ^ flip;

  assign res_err    = err_q;
  assign res_kind   = kind_q;
  assign res_fixed  = err_q ? '0 : fixed_q;
endmodule

// File: rtl/ecc_flip_chk.sv
module ecc_flip_chk
  import ecc_flip_pkg::*;
#(
  parameter int MAX_LOC = 16,
  localparam int CNT_W = $clog2(MAX_LOC + 1)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               mode_q,
  input logic               ev_clean,
  input logic               ev_erased,
  input logic               ev_bad,
  input logic               busy,
  input logic               done,
  input logic               res_err,
  input logic [1:0]         res_kind,
  input logic [CNT_W-1:0]   res_fixed,
  input logic               dbuf_rd,
  input logic               dbuf_wr,
  input logic [DADDR_W-1:0] dbuf_addr,
  input logic               ebuf_rd,
  input logic               ebuf_wr,
  input logic [EADDR_W-1:0] ebuf_addr
);
  a_r1_clean_done: assert property (@(posedge clk) disable iff (!rst_n)
    ev_clean |=> done && res_kind == 2'd1 && !res_err && res_fixed == '0);

  a_r2_erased_done: assert property (@(posedge clk) disable iff (!rst_n)
    ev_erased |=> done && res_kind == 2'd2 && !res_err);

  a_r5_ecc_range: assert property (@(posedge clk) disable iff (!rst_n)
    ebuf_wr |-> ebuf_addr < (mode_q ? EADDR_W'(B16_USED) : EADDR_W'(B8_USED)));

  a_r6_bad_no_read: assert property (@(posedge clk) disable iff (!rst_n)
    ev_bad |=> !dbuf_rd && !ebuf_rd);

  a_r7_data_rmw: assert property (@(posedge clk) disable iff (!rst_n)
    dbuf_wr |-> $past(dbuf_rd) && dbuf_addr == $past(dbuf_addr));

  a_r7_ecc_rmw: assert property (@(posedge clk) disable iff (!rst_n)
    ebuf_wr |-> $past(ebuf_rd) && ebuf_addr == $past(ebuf_addr));

  a_r7_one_access: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({dbuf_rd, dbuf_wr, ebuf_rd, ebuf_wr}));

  a_r8_fixed_bound: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> res_fixed <= CNT_W'(MAX_LOC));

  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy);
endmodule

bind ecc_flip_unit ecc_flip_chk #(.MAX_LOC(MAX_LOC)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .mode_q   (mode_q),
  .ev_clean (ev_clean),
  .ev_erased(ev_erased),
  .ev_bad   (ev_bad),
  .busy     (busy),
  .done     (done),
  .res_err  (res_err),
  .res_kind (res_kind),
  .res_fixed(res_fixed),
  .dbuf_rd  (dbuf_rd),
  .dbuf_wr  (dbuf_wr),
  .dbuf_addr(dbuf_addr),
  .ebuf_rd  (ebuf_rd),
  .ebuf_wr  (ebuf_wr),
  .ebuf_addr(ebuf_addr)
);

// File: tb/tb_ecc_flip_unit.sv
module tb_ecc_flip_unit;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         start, mode16;
  logic [207:0] stored_ecc, calc_ecc;
  logic         busy, syn_valid;
  logic [207:0] syn_out;
  logic         cnt_valid, cnt_ready;
  logic [4:0]   cnt_value;
  logic         loc_valid, loc_ready;
  logic [12:0]  loc_value;
  logic         dbuf_rd, dbuf_wr, ebuf_rd, ebuf_wr;
  logic [8:0]   dbuf_addr;
  logic [4:0]   ebuf_addr;
  logic [7:0]   dbuf_rdata, dbuf_wdata, ebuf_rdata, ebuf_wdata;
  logic         done, res_err;
  logic [1:0]   res_kind;
  logic [4:0]   res_fixed;

  always #5 clk = ~clk;

  ecc_flip_unit dut (.*);

  int n_chk = 0;
  int n_fail = 0;

  logic [7:0] dmem [512];
  logic [7:0] emem [26];

  typedef struct { bit is_ecc; int addr; int mask; } wexp_t;
  wexp_t wq[$];
  wexp_t mon_e;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  // buffer models, one-cycle read latency
  always @(posedge clk) begin
    if (dbuf_rd) dbuf_rdata <= dmem[dbuf_addr];
    if (ebuf_rd) ebuf_rdata <= emem[ebuf_addr];
    if (dbuf_wr) dmem[dbuf_addr] <= dbuf_wdata;
    if (ebuf_wr) emem[ebuf_addr] <= ebuf_wdata;
  end

  // every-clock write monitor against the expected flip queue
  always @(negedge clk) begin
    if (rst_n && (dbuf_wr || ebuf_wr)) begin
      if (wq.size() == 0) begin
        chk(1'b0, "R7", "write with nothing expected", {dbuf_wr, ebuf_wr}, 0);
      end else begin
        mon_e = wq.pop_front();
        chk(ebuf_wr == mon_e.is_ecc, "R5", "buffer select", ebuf_wr, mon_e.is_ecc);
        if (mon_e.is_ecc) begin
          chk(int'(ebuf_addr) == mon_e.addr, "R5", "ecc addr", ebuf_addr, mon_e.addr);
          chk(int'(ebuf_wdata) == (int'(emem[mon_e.addr]) ^ mon_e.mask), "R7", "ecc wdata",
              ebuf_wdata, int'(emem[mon_e.addr]) ^ mon_e.mask);
        end else begin
          chk(int'(dbuf_addr) == mon_e.addr, "R4", "data addr", dbuf_addr, mon_e.addr);
          chk(int'(dbuf_wdata) == (int'(dmem[mon_e.addr]) ^ mon_e.mask), "R7", "data wdata",
              dbuf_wdata, int'(dmem[mon_e.addr]) ^ mon_e.mask);
        end
      end
    end
  end

  function automatic logic [207:0] fill(input int from, input int to, input int val,
                                        input logic [207:0] base);
    logic [207:0] v = base;
    for (int i = from; i <= to; i++) v[8*i +: 8] = 8'(val);
    return v;
  endfunction

  task automatic run_case(input string name, input bit m16, input logic [207:0] st,
                          input logic [207:0] cc, input int cnt, input int locs[$]);
    int slot = m16 ? 26 : 14;
    int lim  = m16 ? 538 : 525;
    bit clean = 1'b1;
    bit erased = 1'b1;
    bit bad = 1'b0;
    int applied = 0;
    int eff;
    logic [207:0] esyn;
    for (int i = 0; i < slot; i++) begin
      if (cc[8*i +: 8] != 8'h00) clean = 1'b0;
      if (st[8*i +: 8] != 8'hFF) erased = 1'b0;
    end
    $display("case %s", name);
    @(negedge clk);
    mode16 = m16; stored_ecc = st; calc_ecc = cc; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy, "R9", "busy after start", busy, 1);
    @(negedge clk);
    if (clean) begin
      chk(done && res_kind == 2'd1 && !res_err && res_fixed == 0, "R1", "clean status",
          {done, res_kind, res_err, res_fixed}, {1'b1, 2'd1, 1'b0, 5'd0});
    end else if (erased) begin
      chk(done && res_kind == 2'd2 && !res_err && res_fixed == 0, "R2", "erased status",
          {done, res_kind, res_err, res_fixed}, {1'b1, 2'd2, 1'b0, 5'd0});
    end else begin
      for (int i = 0; i < 26; i++) begin
        if (m16) esyn[8*i +: 8] = cc[8*(25-i) +: 8];
        else if (i < 13) esyn[8*i +: 8] = cc[8*(12-i) +: 8];
        else if (i == 13) esyn[8*i +: 8] = cc[8*13 +: 8];
        else esyn[8*i +: 8] = 8'h00;
      end
      chk(syn_valid && !done, "R3", "syn_valid", syn_valid, 1);
      chk(syn_out == esyn, "R3", "reversed code", syn_out[63:0], esyn[63:0]);
      chk(cnt_ready, "R8", "count ready", cnt_ready, 1);
      cnt_valid = 1'b1; cnt_value = 5'(cnt);
      @(negedge clk);
      cnt_valid = 1'b0;
      eff = (cnt > 16) ? 16 : cnt;
      if (eff == 0) begin
        chk(done && res_fixed == 0 && !res_err, "R8", "zero count done",
            {done, res_fixed}, {1'b1, 5'd0});
      end else begin
        for (int k = 0; k < eff; k++) begin
          int L = locs[k];
          int pos = lim - 1 - L / 8;
          bit is_ecc = (pos >= 512);
          int addr = is_ecc ? pos - 512 : pos;
          chk(loc_ready, "R7", "location ready", loc_ready, 1);
          loc_valid = 1'b1; loc_value = 13'(L);
          if (pos < 0) bad = 1'b1;
          if (!bad) wq.push_back('{is_ecc, addr, 1 << (L % 8)});
          @(negedge clk);
          loc_valid = 1'b0;
          if (!bad) begin
            chk(is_ecc ? (ebuf_rd && int'(ebuf_addr) == addr) : (dbuf_rd && int'(dbuf_addr) == addr),
                is_ecc ? "R5" : "R4", "read strobe and addr",
                is_ecc ? int'(ebuf_addr) : int'(dbuf_addr), addr);
            @(negedge clk);
            chk(is_ecc ? ebuf_wr : dbuf_wr, "R7", "write one cycle after read", 0, 1);
            applied++;
            @(negedge clk);
          end else begin
            chk(!dbuf_rd && !ebuf_rd, "R6", "no read for dropped location",
                {dbuf_rd, ebuf_rd}, 0);
          end
        end
        chk(done, "R9", "done after last location", done, 1);
        chk(res_err == bad, "R6", "error flag", res_err, bad);
        chk(int'(res_fixed) == (bad ? 0 : applied), bad ? "R6" : "R9", "fixed count",
            res_fixed, bad ? 0 : applied);
        chk(res_kind == 2'd0, "R9", "kind located", res_kind, 0);
      end
      chk(wq.size() == 0, "R7", "all expected flips seen", wq.size(), 0);
    end
    @(negedge clk);
    chk(!done && !busy, "R9", "idle after done", {done, busy}, 0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog act=0 exp=1");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [207:0] st, cc;
    rst_n = 1'b0; start = 1'b0; mode16 = 1'b0; stored_ecc = '0; calc_ecc = '0;
    cnt_valid = 1'b0; cnt_value = '0; loc_valid = 1'b0; loc_value = '0;
    dbuf_rdata = '0; ebuf_rdata = '0;
    for (int i = 0; i < 512; i++) dmem[i] = 8'(i * 29 + 7);
    for (int i = 0; i < 26; i++) emem[i] = 8'(i * 53 + 1);
    repeat (3) @(negedge clk);
    chk(!busy && !done && !cnt_ready && !loc_ready && !syn_valid, "R9", "reset idle",
        {busy, done, cnt_ready, loc_ready, syn_valid}, 0);
    chk(!dbuf_rd && !dbuf_wr && !ebuf_rd && !ebuf_wr, "R7", "reset no strobes",
        {dbuf_rd, dbuf_wr, ebuf_rd, ebuf_wr}, 0);
    rst_n = 1'b1;

    // R1: 8-bit mode, zero slot, junk above the slot is ignored
    cc = fill(14, 25, 8'h5C, '0);
    st = fill(0, 25, 8'h31, '0);
    run_case("clean8", 1'b0, st, cc, 0, '{});

    // R2: 16-bit mode, last byte nonzero so not clean, stored all ones
    cc = fill(25, 25, 8'h01, '0);
    run_case("erased16", 1'b1, fill(0, 25, 8'hFF, '0), cc, 0, '{});

    // R2: 8-bit mode erased, stored bytes above the slot ignored
    st = fill(14, 25, 8'h00, fill(0, 13, 8'hFF, '0));
    cc = fill(0, 25, 8'hA7, '0);
    run_case("erased8", 1'b0, st, cc, 0, '{});

    // R4 R5 R3: reserved byte breaks the erased screen, four boundary flips
    st = fill(13, 13, 8'h00, fill(0, 12, 8'hFF, '0));
    for (int i = 0; i < 26; i++) cc[8*i +: 8] = 8'(i * 17 + 3);
    run_case("located8", 1'b0, st, cc, 4, '{0, 104, 4199, 101});

    // R8 R4 R5: count 31 treated as 16, repeated byte, both ends of the word
    for (int i = 0; i < 26; i++) cc[8*i +: 8] = 8'(200 - i * 7);
    run_case("located16", 1'b1, '0, cc, 31,
             '{0, 208, 4303, 207, 1000, 1000, 1500, 2048, 3000, 4000, 333, 77, 4111, 2500, 900, 16});

    // R6: invalid location in the middle suppresses the rest
    run_case("bad8", 1'b0, '0, cc, 4, '{50, 4200, 60, 4300});

    // R8: zero count
    run_case("zero16", 1'b1, '0, cc, 0, '{});

    // R6: first location just past the 16-bit limit
    run_case("edge16", 1'b1, '0, cc, 1, '{4304});

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule